// File: doc/BRIEF.md
# Downcounting Watchdog Timer with Bit-6 Expiry

This block guards a processor against runaway software. A 7-bit counter counts down once per prescaler period, and software must reload it through an 8-bit control register before counter bit 6 clears. Bit 7 of the register arms the watchdog and bits 6:0 hold the counter. Once the watchdog is armed, the counter stepping from 40h to 3Fh starts a reset pulse of fixed length on `wdg_rst`.

The prescaler runs freely and register writes do not clear it. The first decrement after a refresh therefore lands between 1 and PRESCALE clocks later. The counter also runs while the watchdog is disarmed and wraps from 00h to 7Fh, but it never causes a reset in that state. Software can arm the watchdog but cannot disarm it. Only a reset disarms it.

Three other events also start a reset pulse. A write that leaves the watchdog armed with bit 6 clear forces one at once. A halt request while armed starts one. A static strap input selects a hardware watchdog that is permanently armed. When the pulse ends, the block starts again from its reset state.

Top module: `wdog_down`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads {`hw_strap`, 7Fh} and `wdg_rst` is low.
- R2: The counter (`rd_data[6:0]`) decrements by one every PRESCALE clocks. After reset or after a pulse ends, the first decrement comes on the PRESCALE-th clock edge. The counter keeps running while disarmed, wraps from 00h to 7Fh, and produces no reset while disarmed.
- R3: A register write (`wr_en` high for one clock) loads `wr_data[6:0]` into the counter. The value can be read back on the next cycle as `rd_data[6:0]`, and `rd_data[7]` shows the armed state.
- R4: Writing `wr_data[7]`=1 arms the watchdog. Writing `wr_data[7]`=0 never disarms it.
- R5: While armed, the decrement from 40h to 3Fh raises `wdg_rst` on the same clock edge. A write of C0h to FFh whose bits 5:0 hold L therefore raises `wdg_rst` between L*PRESCALE+1 and (L+1)*PRESCALE clock edges after the write edge.
- R6: A write that leaves the watchdog armed with `wr_data[6]`=0 raises `wdg_rst` on the write's own clock edge. This covers writing bit 7 set, or the watchdog already being armed.
- R7: `halt_req` raises `wdg_rst` on the next edge when the watchdog is armed, and has no effect when it is disarmed.
- R8: `wdg_rst` stays high for exactly RST_CYCLES cycles. When it falls, the counter reads 7Fh, the armed bit equals `hw_strap`, and the prescaler restarts from zero.
- R9: With `hw_strap` high, the watchdog is armed out of reset and stays armed. From reset it times out after exactly 64*PRESCALE clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write value: bit 7 arm, bits 6:0 counter |
| halt_req | input | 1 | Halt request from the core |
| hw_strap | input | 1 | Static strap selecting the hardware watchdog |
| rd_data | output | 8 | Read value: {armed, counter} |
| wdg_rst | output | 1 | Active-high reset pulse |

## Verification
The bench uses a short prescaler so that it can follow the disarmed counter over a full wrap and more. It compares every cycle against the floor of elapsed clocks over PRESCALE. This exposes both a wrong tick rate and any reset leaking out while disarmed. Timeouts are measured for several refresh values, from the smallest reload up to the largest. Each delay must fall inside the window that the unknown prescaler phase allows, which separates off-by-one tick counting from a wrong trip value. The software-forced, halt and strap paths are each tried both armed and disarmed. This shows that the same stimulus resets in one case and is ignored in the other. After each pulse the bench also measures the pulse width and the restart state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W    = 8;
    localparam int CNT_W    = REG_W - 1;
    localparam int ARM_BIT  = REG_W - 1;
    localparam int TRIP_BIT = CNT_W - 1;
    localparam logic [CNT_W-1:0] CNT_INIT  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TRIP_FROM = CNT_W'(1) << TRIP_BIT;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } ctl_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRESCALE = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (hold) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            tick    = 1'b1;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             halt_req,
    input  logic             hw_strap,
    output logic [REG_W-1:0] rd_data,
    output logic             trip
);
    ctl_state_t s_d, s_q;
    logic armed_now;
    logic trip_wr, trip_tick, trip_halt;

    assign armed_now = s_q.armed | hw_strap;

    always_comb begin
        s_d       = s_q;
        trip_wr   = 1'b0;
        trip_tick = 1'b0;
        trip_halt = 1'b0;
        if (hold) begin
            s_d.armed = 1'b0;
            s_d.cnt   = CNT_INIT;
        end else begin
            trip_halt = halt_req & armed_now;
            if (wr_en) begin
                s_d.cnt   = wr_data[CNT_W-1:0];
                s_d.armed = s_q.armed | wr_data[ARM_BIT];
                trip_wr   = (armed_now | wr_data[ARM_BIT]) & ~wr_data[TRIP_BIT];
            end else if (tick) begin
                s_d.cnt   = s_q.cnt - CNT_W'(1);
                trip_tick = armed_now && (s_q.cnt == TRIP_FROM);
            end
        end
        trip = trip_wr | trip_tick | trip_halt;
    end

    assign rd_data = {armed_now, s_q.cnt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.armed <= 1'b0;
            s_q.cnt   <= CNT_INIT;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int RST_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic active
);
    localparam int LW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [LW-1:0] LOAD = LW'(RST_CYCLES - 1);

    typedef struct packed {
        logic          on;
        logic [LW-1:0] left;
    } pulse_state_t;

    pulse_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.on) begin
            if (s_q.left == '0) s_d.on = 1'b0;
            else                s_d.left = s_q.left - LW'(1);
        end else if (trip) begin
            s_d.on   = 1'b1;
            s_d.left = LOAD;
        end
    end

    assign active = s_q.on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_down.sv
module wdog_down
    import wdog_pkg::*;
#(
    parameter int PRESCALE   = 16384,
    parameter int RST_CYCLES = 6000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             halt_req,
    input  logic             hw_strap,
    output logic [REG_W-1:0] rd_data,
    output logic             wdg_rst
);
    logic tick;
    logic trip;

    wdog_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (wdg_rst),
        .tick  (tick)
    );

    wdog_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (wdg_rst),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .halt_req (halt_req),
        .hw_strap (hw_strap),
        .rd_data  (rd_data),
        .trip     (trip)
    );

    wdog_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (trip),
        .active (wdg_rst)
    );
endmodule

// File: rtl/wdog_down_chk.sv
module wdog_down_chk #(
    parameter int RST_CYCLES = 6000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_top,
    input logic       halt_req,
    input logic       hw_strap,
    input logic [7:0] rd_data,
    input logic       wdg_rst,
    input logic       tick
);
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= 0;
        else if (wdg_rst) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wdg_rst && !tick) |=> $stable(rd_data[6:0]));

    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !wdg_rst) |=> rd_data[6:0] == 7'($past(rd_data[6:0]) - 7'd1));

    a_r2_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdg_rst && !rd_data[7] && !(wr_en && wr_top[1])) |=> !wdg_rst);

    a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !wdg_rst) |=> (rd_data[7] || wdg_rst));

    a_r5_trip_on_40h: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_data[7] && rd_data[6:0] == 7'h40 && !wr_en && !wdg_rst) |=> wdg_rst);

    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top == 2'b10 && !wdg_rst) |=> wdg_rst);

    a_r7_halt_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && rd_data[7] && !wdg_rst) |=> wdg_rst);

    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |-> (run_q < RST_CYCLES));

    a_r8_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdg_rst) |-> ($past(run_q) == RST_CYCLES - 1));

    a_r9_strap_armed: assert property (@(posedge clk) disable iff (!rst_n)
        hw_strap |-> rd_data[7]);
endmodule

bind wdog_down wdog_down_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_top   (wr_data[7:6]),
    .halt_req (halt_req),
    .hw_strap (hw_strap),
    .rd_data  (rd_data),
    .wdg_rst  (wdg_rst),
    .tick     (tick)
);

// File: tb/wdog_down_bench.sv
`timescale 1ns/1ps
module wdog_down_bench;
    localparam int P  = 4;
    localparam int RC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       halt_req = 1'b0;
    logic       hw_strap = 1'b0;
    logic [7:0] rd_data;
    logic       wdg_rst;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdog_down #(.PRESCALE(P), .RST_CYCLES(RC)) u_wdog_down (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .halt_req(halt_req), .hw_strap(hw_strap),
        .rd_data(rd_data), .wdg_rst(wdg_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reset_dut(input bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        hw_strap = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts negedges until wdg_rst is seen high
    task automatic wait_rst(output int n);
        n = 0;
        while (!wdg_rst && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // measures the pulse and checks the restart state (R8)
    task automatic pulse_and_restart(input logic strap);
        int m = 0;
        while (wdg_rst && m < 100) begin
            @(negedge clk);
            m++;
        end
        chk(m == RC, "R8 width", m, RC);
        chk(rd_data == {strap, 7'h7F}, "R8 restart", rd_data, {strap, 7'h7F});
        for (int j = 1; j <= 3 * P; j++) begin
            @(negedge clk);
            chk(rd_data[6:0] == 7'(7'h7F - j / P), "R8 prescaler restart",
                rd_data[6:0], 7'(7'h7F - j / P));
        end
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        logic [5:0] lv [6] = '{6'd0, 6'd1, 6'd2, 6'd7, 6'd20, 6'd63};

        // R1 reset state
        reset_dut(1'b0);
        chk(rd_data == 8'h7F, "R1 read", rd_data, 8'h7F);
        chk(wdg_rst == 1'b0, "R1 rst low", wdg_rst, 0);

        // R2 free-running sweep across a full wrap while disarmed
        for (int j = 0; j <= 600; j++) begin
            chk(rd_data == {1'b0, 7'(7'h7F - j / P)} && !wdg_rst, "R2 sweep",
                {wdg_rst, rd_data}, {1'b0, 7'(7'h7F - j / P)});
            @(negedge clk);
        end

        // R3 load while disarmed, no arming, no reset when crossing 40h
        wr(8'h20);
        chk(rd_data == 8'h20, "R3 load", rd_data, 8'h20);
        n = 0;
        for (int j = 0; j < 420; j++) begin
            if (wdg_rst) n++;
            @(negedge clk);
        end
        chk(n == 0 && rd_data[7] == 1'b0, "R2 disarmed no reset", n, 0);

        // R7 halt while disarmed
        halt_req = 1'b1;
        repeat (4) @(negedge clk);
        halt_req = 1'b0;
        chk(wdg_rst == 1'b0 && rd_data[7] == 1'b0, "R7 halt disarmed", wdg_rst, 0);

        // R4 arm then try to disarm
        wr(8'hC5);
        chk(rd_data == 8'hC5, "R3 armed read", rd_data, 8'hC5);
        wr(8'h45);
        chk(rd_data == 8'hC5 && !wdg_rst, "R4 sticky", rd_data, 8'hC5);

        // R6 via sticky arm: bit7=0, bit6=0
        wr(8'h05);
        chk(wdg_rst == 1'b1, "R6 sticky soft reset", wdg_rst, 1);
        pulse_and_restart(1'b0);

        // R6 direct soft reset from disarmed state
        wr(8'hBF);
        chk(wdg_rst == 1'b1, "R6 soft reset", wdg_rst, 1);
        pulse_and_restart(1'b0);

        // R5 timeout windows
        foreach (lv[i]) begin
            wr({2'b11, lv[i]});
            wait_rst(n);
            chk(n >= lv[i] * P + 1 && n <= (lv[i] + 1) * P, "R5 timeout window",
                n, (lv[i] + 1) * P);
            pulse_and_restart(1'b0);
        end

        // R7 halt while armed
        wr(8'hFF);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk(wdg_rst == 1'b1, "R7 halt armed", wdg_rst, 1);
        pulse_and_restart(1'b0);

        // R9 hardware strap
        reset_dut(1'b1);
        chk(rd_data == 8'hFF, "R1 R9 strap reset", rd_data, 8'hFF);
        wait_rst(n);
        chk(n == 64 * P, "R9 strap timeout", n, 64 * P);
        pulse_and_restart(1'b1);
        wr(8'h7F);
        chk(rd_data == 8'hFF, "R9 strap stays armed", rd_data, 8'hFF);

        reset_dut(1'b0);
        chk(rd_data == 8'h7F, "R1 strap released", rd_data, 8'h7F);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule